// File: doc/BRIEF.md
# UART Interrupt Identification and Prioritisation

This block gathers the four interrupt causes of a UART into one request line for the host. It also presents a 4-bit identification code naming the most urgent cause that is both pending and enabled. The causes are a latched line error, receive data at or above the trigger level, a receive timeout and an empty transmit holding register. Each cause has its own enable, and the enables only mask: a cause that is disabled keeps its pending state, and it is reported as soon as its enable is set.

Each cause clears in its own way. A line error stays latched until the host reads the line status. Receive data pending follows the FIFO fill level against the trigger level. The timeout counts character-time ticks while the receive FIFO holds data. Any arriving character or any data read restarts that count. The transmit-empty cause clears when the identification is read while it is the reported cause, or when new transmit data is written.

Three state machines hold this state. The line flag has states LS_CLEAR and LS_SET. The timeout has TMO_IDLE, TMO_COUNT and TMO_FIRED. The transmit tracker has THR_BUSY, THR_PEND and THR_ACKED. The transitions are: LS_CLEAR→LS_SET on an error, LS_SET→LS_CLEAR on a status read without a new error. TMO_IDLE→TMO_COUNT when the FIFO is non-empty. TMO_COUNT→TMO_FIRED on the last tick. TMO_FIRED→TMO_COUNT on a read or a new character. Any timeout state→TMO_IDLE when the FIFO is empty. THR_BUSY→THR_PEND when the holding register is empty. THR_PEND→THR_ACKED on an identification read while this cause is reported. THR_PEND or THR_ACKED→THR_BUSY on a write or when the register is no longer empty.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, irq_o is 0 and iid_o is 4'b0001.
- R2: iid_o bit 0 is 1 exactly when no enabled cause is pending, and irq_o is the inverse of iid_o bit 0. Bits 3:1 encode the cause as follows: line error 011 (iid_o=6), receive data 010 (4), timeout 110 (12), transmit empty 001 (2).
- R3: When several enabled causes are pending, the one reported is the first of this order: line error, receive data, timeout, transmit empty.
- R4: A line_err_i pulse latches the line cause from the next cycle on. It stays latched until a cycle with rd_lsr_i and no line_err_i. When line_err_i and rd_lsr_i fall in the same cycle, the cause remains latched.
- R5: The receive data cause is pending while rx_level_i is non-zero and rx_level_i >= rx_trig_i. It drops as soon as the level falls below the trigger.
- R6: With a non-empty FIFO, the timeout cause becomes pending one cycle after the TMO_CHARS-th (default 4) char_tick_i pulse counted without any rx_char_i or rd_data_i. Either of those strobes restarts the count.
- R7: A pending timeout clears the cycle after rd_data_i, or the cycle after rx_level_i is zero.
- R8: The transmit-empty cause becomes pending the cycle after tx_empty_i goes high. It is cleared by rd_iid_i only in a cycle in which it is the reported cause. An identification read while another cause is reported leaves it pending.
- R9: tx_write_i clears the transmit-empty cause on the next cycle. It becomes pending again when tx_empty_i is high after the holding register was busy.
- R10: A disabled cause neither raises irq_o nor appears in iid_o. Its pending state is kept and is reported once it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_err_i | input | 1 | Pulse: overrun, parity, framing or break detected |
| rx_level_i | input | LVL_W | Receive FIFO fill count |
| rx_trig_i | input | LVL_W | Receive trigger level |
| rx_char_i | input | 1 | Pulse: a character entered the receive FIFO |
| char_tick_i | input | 1 | Pulse once per character time |
| tx_empty_i | input | 1 | Transmit holding register is empty |
| tx_write_i | input | 1 | Strobe: host writes transmit data |
| en_line_i | input | 1 | Enable for the line error cause |
| en_rxd_i | input | 1 | Enable for the receive data cause |
| en_tmo_i | input | 1 | Enable for the timeout cause |
| en_thr_i | input | 1 | Enable for the transmit-empty cause |
| rd_iid_i | input | 1 | Strobe: host reads the identification |
| rd_data_i | input | 1 | Strobe: host reads receive data |
| rd_lsr_i | input | 1 | Strobe: host reads line status |
| irq_o | output | 1 | Interrupt request |
| iid_o | output | 4 | Identification code |

## Verification
Two pairs of events can land in the same cycle. In the first, a new line error arrives together with the status read that would clear the old one. The bench drives both strobes on one edge and expects the line cause to stay latched. In the second, the identification is read while transmit-empty is reported, and a line error arrives in that same cycle. The bench expects the line code to win on the next cycle and the transmit-empty cause to be gone once the line status has been read. On top of this, a sweep covers all 16 pending patterns against all 16 enable masks, and the expected code is computed by the priority rule.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;

    localparam int NSRC = 4;

    // Index equals priority rank: 0 is the most urgent cause
    localparam int SRC_LINE = 0;
    localparam int SRC_RXD  = 1;
    localparam int SRC_TMO  = 2;
    localparam int SRC_THR  = 3;

    localparam logic [3:0] IID_NONE = 4'b0001;

    typedef enum logic [1:0] {
        LS_CLEAR = 2'd0,
        LS_SET   = 2'd1
    } ls_state_e;

    typedef enum logic [1:0] {
        TMO_IDLE  = 2'd0,
        TMO_COUNT = 2'd1,
        TMO_FIRED = 2'd2
    } tmo_state_e;

    typedef enum logic [1:0] {
        THR_BUSY  = 2'd0,
        THR_PEND  = 2'd1,
        THR_ACKED = 2'd2
    } thr_state_e;

    function automatic logic [3:0] iid_code(input int unsigned idx);
        logic [3:0] c;
        case (idx)
            SRC_LINE: c = 4'b0110;
            SRC_RXD:  c = 4'b0100;
            SRC_TMO:  c = 4'b1100;
            SRC_THR:  c = 4'b0010;
            default:  c = IID_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/uart_iid_line_flag.sv
module uart_iid_line_flag
    import uart_iid_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic err_i,
    input  logic rd_lsr_i,
    output logic pend_o
);

    ls_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= LS_CLEAR;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_CLEAR: if (err_i) state_d = LS_SET;
            LS_SET:   if (rd_lsr_i && !err_i) state_d = LS_CLEAR;
            default:  state_d = LS_CLEAR;
        endcase
    end

    always_comb begin
        pend_o = (state_q == LS_SET);
    end

    // R4: an error is latched on the next cycle, even alongside a status read
    p_err_latched_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_i |=> pend_o);

    // R4: a latched error persists until a status read
    p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_o && !rd_lsr_i) |=> pend_o);

endmodule

// File: rtl/uart_iid_rx_timeout.sv
module uart_iid_rx_timeout
    import uart_iid_pkg::*;
#(
    parameter int LVL_W     = 5,
    parameter int TMO_CHARS = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [LVL_W-1:0] rx_level_i,
    input  logic             rx_char_i,
    input  logic             rd_data_i,
    input  logic             char_tick_i,
    output logic             pend_o
);

    localparam int CNT_W = $clog2(TMO_CHARS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CHARS - 1);

    tmo_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             fifo_empty;
    logic             activity;

    always_comb begin
        fifo_empty = (rx_level_i == '0);
        activity   = rx_char_i || rd_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= TMO_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TMO_IDLE: begin
                cnt_d = '0;
                if (!fifo_empty) state_d = TMO_COUNT;
            end
            TMO_COUNT: begin
                if (fifo_empty) begin
                    state_d = TMO_IDLE;
                    cnt_d   = '0;
                end else if (activity) begin
                    cnt_d = '0;
                end else if (char_tick_i) begin
                    if (cnt_q == CNT_LAST) begin
                        state_d = TMO_FIRED;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            TMO_FIRED: begin
                cnt_d = '0;
                if (fifo_empty)    state_d = TMO_IDLE;
                else if (activity) state_d = TMO_COUNT;
            end
            default: begin
                state_d = TMO_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        pend_o = (state_q == TMO_FIRED);
    end

    // R7: an empty FIFO leaves no timeout pending
    p_empty_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fifo_empty |=> !pend_o);

    // R7: a data read removes a pending timeout
    p_read_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_i |=> !pend_o);

    // R6: the timeout can only fire on a tick
    p_fire_on_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pend_o && !char_tick_i) |=> !pend_o);

endmodule

// File: rtl/uart_iid_thr_track.sv
module uart_iid_thr_track
    import uart_iid_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tx_empty_i,
    input  logic tx_write_i,
    input  logic rd_iid_i,
    input  logic granted_i,
    output logic pend_o
);

    thr_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= THR_BUSY;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            THR_BUSY: begin
                if (tx_empty_i && !tx_write_i) state_d = THR_PEND;
            end
            THR_PEND: begin
                if (tx_write_i || !tx_empty_i)   state_d = THR_BUSY;
                else if (rd_iid_i && granted_i)  state_d = THR_ACKED;
            end
            THR_ACKED: begin
                if (tx_write_i || !tx_empty_i)   state_d = THR_BUSY;
            end
            default: state_d = THR_BUSY;
        endcase
    end

    always_comb begin
        pend_o = (state_q == THR_PEND);
    end

    // R8: reading the identification while reported acknowledges the cause
    p_ack_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_iid_i && granted_i) |=> !pend_o);

    // R9: a transmit write removes the cause
    p_write_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_write_i |=> !pend_o);

    // R8: without a read or write, a pending cause stays while the register is empty
    p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_o && tx_empty_i && !rd_iid_i && !tx_write_i) |=> pend_o);

endmodule

// File: rtl/uart_iid_prio.sv
module uart_iid_prio
    import uart_iid_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0] pend_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] grant_o,
    output logic         irq_o,
    output logic [3:0]   iid_o
);

    logic [N-1:0] req;

    for (genvar g = 0; g < N; g++) begin : g_mask
        assign req[g] = pend_i[g] & en_i[g];
    end

    always_comb begin
        grant_o = '0;
        iid_o   = IID_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                iid_o      = iid_code(i);
            end
        end
        irq_o = |req;
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_iid_pkg::*;
#(
    parameter int LVL_W     = 5,
    parameter int TMO_CHARS = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             line_err_i,
    input  logic [LVL_W-1:0] rx_level_i,
    input  logic [LVL_W-1:0] rx_trig_i,
    input  logic             rx_char_i,
    input  logic             char_tick_i,
    input  logic             tx_empty_i,
    input  logic             tx_write_i,
    input  logic             en_line_i,
    input  logic             en_rxd_i,
    input  logic             en_tmo_i,
    input  logic             en_thr_i,
    input  logic             rd_iid_i,
    input  logic             rd_data_i,
    input  logic             rd_lsr_i,
    output logic             irq_o,
    output logic [3:0]       iid_o
);

    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] en;
    logic [NSRC-1:0] grant;
    logic            line_pend;
    logic            tmo_pend;
    logic            thr_pend;
    logic            rxd_pend;

    always_comb begin
        rxd_pend = (rx_level_i != '0) && (rx_level_i >= rx_trig_i);
    end

    uart_iid_line_flag u_line (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .err_i    (line_err_i),
        .rd_lsr_i (rd_lsr_i),
        .pend_o   (line_pend)
    );

    uart_iid_rx_timeout #(
        .LVL_W     (LVL_W),
        .TMO_CHARS (TMO_CHARS)
    ) u_tmo (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .rx_level_i  (rx_level_i),
        .rx_char_i   (rx_char_i),
        .rd_data_i   (rd_data_i),
        .char_tick_i (char_tick_i),
        .pend_o      (tmo_pend)
    );

    uart_iid_thr_track u_thr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tx_empty_i (tx_empty_i),
        .tx_write_i (tx_write_i),
        .rd_iid_i   (rd_iid_i),
        .granted_i  (grant[SRC_THR]),
        .pend_o     (thr_pend)
    );

    always_comb begin
        pend            = '0;
        pend[SRC_LINE]  = line_pend;
        pend[SRC_RXD]   = rxd_pend;
        pend[SRC_TMO]   = tmo_pend;
        pend[SRC_THR]   = thr_pend;
        en              = '0;
        en[SRC_LINE]    = en_line_i;
        en[SRC_RXD]     = en_rxd_i;
        en[SRC_TMO]     = en_tmo_i;
        en[SRC_THR]     = en_thr_i;
    end

    uart_iid_prio #(.N(NSRC)) u_prio (
        .pend_i  (pend),
        .en_i    (en),
        .grant_o (grant),
        .irq_o   (irq_o),
        .iid_o   (iid_o)
    );

    // R2: the request line and the "none pending" bit are always opposite
    p_irq_matches_code_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o != iid_o[0]);

    // R3: an enabled line error always wins
    p_line_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (line_pend && en_line_i) |-> (iid_o == 4'b0110));

    // R3: at most one cause is granted
    p_one_grant_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(grant));

    // R10: a disabled transmit-empty cause is never granted
    p_mask_thr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_thr_i |-> !grant[SRC_THR]);

endmodule

// File: tb/test_uart_irq_ident.sv
`timescale 1ns/1ps
module test_uart_irq_ident;

    localparam int LVL_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             line_err = 0, rx_char = 0, char_tick = 0;
    logic             tx_empty = 0, tx_write = 0;
    logic             en_line = 0, en_rxd = 0, en_tmo = 0, en_thr = 0;
    logic             rd_iid = 0, rd_data = 0, rd_lsr = 0;
    logic [LVL_W-1:0] rx_level = '0;
    logic [LVL_W-1:0] rx_trig  = 5'd2;
    logic             irq;
    logic [3:0]       iid;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    uart_irq_ident #(.LVL_W(LVL_W), .TMO_CHARS(4)) i_uart_irq_ident (
        .clk_i(clk), .rst_ni(rst_n), .line_err_i(line_err),
        .rx_level_i(rx_level), .rx_trig_i(rx_trig), .rx_char_i(rx_char),
        .char_tick_i(char_tick), .tx_empty_i(tx_empty), .tx_write_i(tx_write),
        .en_line_i(en_line), .en_rxd_i(en_rxd), .en_tmo_i(en_tmo), .en_thr_i(en_thr),
        .rd_iid_i(rd_iid), .rd_data_i(rd_data), .rd_lsr_i(rd_lsr),
        .irq_o(irq), .iid_o(iid)
    );

    function automatic logic [3:0] expect_code(input int m);
        if (m[0])      return 4'd6;
        else if (m[1]) return 4'd4;
        else if (m[2]) return 4'd12;
        else if (m[3]) return 4'd2;
        return 4'd1;
    endfunction

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [3:0] exp);
        logic ex_irq;
        #1;
        ex_irq = (exp != 4'd1);
        checks++;
        if (iid !== exp || irq !== ex_irq) begin
            fails++;
            $display("FAIL %s: iid=%0d irq=%0b expected iid=%0d irq=%0b",
                     req, iid, irq, exp, ex_irq);
        end
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            char_tick = 1; cyc(); char_tick = 0; cyc();
        end
    endtask

    task automatic do_reset();
        rst_n = 0; cyc(); cyc(); rst_n = 1; cyc();
    endtask

    task automatic enables(input int m);
        en_line = m[0]; en_rxd = m[1]; en_tmo = m[2]; en_thr = m[3];
    endtask

    initial begin
        #1_000_000;
        fails++; checks++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1", 4'd1);

        // R2 R3 R10: all pending patterns against all enable masks
        for (int p = 0; p < 16; p++) begin
            rx_level = '0; tx_empty = 0; enables(0);
            do_reset();
            tx_empty = p[3];
            if (p[1])      rx_level = 5'd2;
            else if (p[2]) rx_level = 5'd1;
            if (p[0]) begin line_err = 1; cyc(); line_err = 0; end
            cyc(); cyc();
            if (p[2]) ticks(4);
            for (int m = 0; m < 16; m++) begin
                enables(m);
                cyc();
                chk("R2/R3/R10 sweep", expect_code(p & m));
            end
        end

        rx_level = '0; tx_empty = 0; enables(15);
        do_reset();

        // R4
        line_err = 1; cyc(); line_err = 0; chk("R4 latch", 4'd6);
        cyc(); chk("R4 hold", 4'd6);
        rd_lsr = 1; cyc(); rd_lsr = 0; chk("R4 clear", 4'd1);
        line_err = 1; cyc(); line_err = 0; chk("R4 latch", 4'd6);
        line_err = 1; rd_lsr = 1; cyc(); line_err = 0; rd_lsr = 0;
        chk("R4 same-cycle error wins", 4'd6);
        rd_lsr = 1; cyc(); rd_lsr = 0; chk("R4 clear", 4'd1);

        // R5
        rx_level = 5'd2; #1; chk("R5 at trigger", 4'd4);
        rx_level = 5'd3; #1; chk("R5 above trigger", 4'd4);
        rx_level = 5'd1; #1; chk("R5 below trigger", 4'd1);
        rx_level = 5'd0; cyc(); cyc();

        // R6 R7
        rx_level = 5'd1; cyc(); cyc();
        ticks(3); chk("R6 three ticks", 4'd1);
        rx_char = 1; cyc(); rx_char = 0;
        ticks(3); chk("R6 restart by char", 4'd1);
        ticks(1); chk("R6 fire", 4'd12);
        rd_data = 1; cyc(); rd_data = 0; chk("R7 read clears", 4'd1);
        ticks(3); chk("R6 restart by read", 4'd1);
        ticks(1); chk("R6 fire again", 4'd12);
        rx_level = 5'd0; cyc(); chk("R7 empty clears", 4'd1);

        // R8 R9
        tx_empty = 1; cyc(); chk("R8 empty raises", 4'd2);
        rd_iid = 1; cyc(); rd_iid = 0; chk("R8 ack by read", 4'd1);
        tx_write = 1; tx_empty = 0; cyc(); tx_write = 0; chk("R9 write", 4'd1);
        tx_empty = 1; cyc(); chk("R9 re-armed", 4'd2);
        line_err = 1; cyc(); line_err = 0; chk("R3 line over thr", 4'd6);
        rd_iid = 1; cyc(); rd_iid = 0; chk("R8 read not reported", 4'd6);
        rd_lsr = 1; cyc(); rd_lsr = 0; chk("R8 still pending", 4'd2);
        rd_iid = 1; line_err = 1; cyc(); rd_iid = 0; line_err = 0;
        chk("R8 ack with new error", 4'd6);
        rd_lsr = 1; cyc(); rd_lsr = 0; chk("R8 acked stays off", 4'd1);
        tx_write = 1; tx_empty = 0; cyc(); tx_write = 0; tx_empty = 1; cyc();
        chk("R9 new empty", 4'd2);
        tx_write = 1; cyc(); tx_write = 0; tx_empty = 0; chk("R9 write clears", 4'd1);

        // R10
        en_line = 0;
        line_err = 1; cyc(); line_err = 0; chk("R10 masked", 4'd1);
        cyc(); en_line = 1; #1; chk("R10 unmasked", 4'd6);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule